// File: doc/BRIEF.md
# LIN Slave Header Synchroniser

This block sits at the receive side of a slave node on a single-wire LIN bus. It tracks how long the receive line stays dominant. A dominant run that is long enough and then ends in a recessive level marks the start of a header. The block then times the master's synchronisation byte (value 0x55) from edge to edge. From that timing it works out the master's actual bit period, in clock cycles, and presents it as a divisor for a UART receiver.

When the measured period lies close enough to the nominal one, the block strobes a success flag. It then receives the protected identifier at the measured rate and checks its two parity bits. A software-loaded table supplies the response action for that identifier: receive, transmit or ignore. The block also reports the response length that the identifier implies. When measurement fails, the block strobes a failure flag and goes back to looking for a break. A fresh break at any point restarts the synchronisation.

Top module: `lin_sync_rx`

## Requirements
- R1: A break is accepted only when the synchronised receive line has been low for at least 11 × `nom_period_i` clock cycles and then returns high; a shorter low run starts nothing, so no strobe follows it.
- R2: After a break, the divisor equals the number of cycles between the falling edge of the start bit and the falling edge of bit 7 of the 0x55 sync byte, divided by 8. It is presented on `divisor_o` together with a one-cycle `sync_ok_o` strobe. `sync_ok_o` and `sync_fail_o` never pulse together.
- R3: When |measured − nominal| × 50 > nominal × 7 (a deviation beyond 14 %), the block pulses `sync_fail_o` instead of `sync_ok_o` and receives no identifier.
- R4: When no falling edge arrives within 20 × `nom_period_i` cycles of the break end or of the previous sync edge, the block pulses `sync_fail_o` and returns to break search.
- R5: An identifier is received only after `sync_ok_o`. Its 8 bits are sampled LSB first at mid-bit using the new divisor. `id_o` takes bits 5:0 and `id_valid_o` pulses for one cycle.
- R6: `action_o` is taken from `act_map_i[2*id+1 : 2*id]`. The code 01 means receive and 10 means transmit. Both 00 and 11 mean ignore, which is output as 00, so `action_o` is never 11.
- R7: Received bit 6 must equal id0^id1^id2^id4 and bit 7 must equal ~(id1^id3^id4^id5). On a mismatch, `parity_err_o` pulses with `id_valid_o` and `action_o` is 00.
- R8: `resp_len_o` gives the response byte count from id[5:4]: 00 or 01 gives 2, 10 gives 4, 11 gives 8.
- R9: A valid break detected in the middle of a sync byte discards the partial measurement and restarts synchronisation.
- R10: After reset, all strobes are low and `divisor_o`, `id_o`, `action_o` and `resp_len_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Bus receive line (asynchronous) |
| nom_period_i | input | CW | Nominal bit period in clock cycles |
| act_map_i | input | 128 | Two-bit action code per identifier |
| divisor_o | output | CW | Measured bit period in cycles |
| sync_ok_o | output | 1 | Synchronisation succeeded (strobe) |
| sync_fail_o | output | 1 | Synchronisation failed (strobe) |
| id_o | output | 6 | Received identifier |
| id_valid_o | output | 1 | Identifier received (strobe) |
| action_o | output | 2 | Response action for the identifier |
| resp_len_o | output | 4 | Response length in bytes |
| parity_err_o | output | 1 | Identifier parity mismatch (strobe) |

## Verification
The receive line passes through two synchroniser stages and one output register. As a result, `sync_ok_o` or `sync_fail_o` rises three cycles after the falling edge of bit 7 of the sync byte. A timeout failure rises 20 nominal periods plus three cycles after the last edge. `id_valid_o` rises three cycles after the middle of the identifier's bit 7. The bench drives whole frames at exact multiples of the master period, and each frame is followed by at least six idle bit times. The bench counts every strobe at the falling clock edge and captures the values that go with it. It then compares the counts and values with its own computed expectations, and the trailing idle time covers every one of these latencies.

// File: rtl/lin_sync_pkg.sv
package lin_sync_pkg;
  localparam int ID_W  = 6;
  localparam int MAP_W = 2 * (1 << ID_W);

  typedef enum logic [1:0] {ACT_IGNORE = 2'b00, ACT_RECV = 2'b01, ACT_XMIT = 2'b10} act_e;
  typedef enum logic [1:0] {M_IDLE, M_FIRST, M_MEAS} meas_st_e;
  typedef enum logic [1:0] {I_IDLE, I_WAIT, I_DATA} idrx_st_e;

  // expected parity pair {bit7, bit6} for a 6-bit identifier
  function automatic logic [1:0] id_parity(input logic [ID_W-1:0] id);
    return {~(id[1] ^ id[3] ^ id[4] ^ id[5]), id[0] ^ id[1] ^ id[2] ^ id[4]};
  endfunction

  function automatic logic [3:0] id_resp_len(input logic [ID_W-1:0] id);
    case (id[5:4])
      2'b10:   return 4'd4;
      2'b11:   return 4'd8;
      default: return 4'd2;
    endcase
  endfunction
endpackage

// File: rtl/lin_rx_front.sv
module lin_rx_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_i,
  output logic lvl_o,
  output logic fall_o,
  output logic rise_o
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-1:0], rx_i};
  end

  assign lvl_o  = sh[STAGES-1];
  assign fall_o = sh[STAGES] & ~sh[STAGES-1];
  assign rise_o = ~sh[STAGES] & sh[STAGES-1];
endmodule

// File: rtl/lin_break_det.sv
module lin_break_det #(
  parameter int CW       = 16,
  parameter int MIN_BITS = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lvl_i,
  input  logic          rise_i,
  input  logic [CW-1:0] nom_i,
  output logic          brk_o
);
  localparam int LW = CW + 4;
  logic [LW-1:0] lowcnt;
  logic [LW-1:0] thr;

  assign thr = LW'(nom_i) * LW'(MIN_BITS);

  always_ff @(posedge clk) begin
    if (rst) begin
      lowcnt <= '0;
      brk_o  <= 1'b0;
    end else begin
      brk_o <= rise_i && (lowcnt >= thr);
      if (lvl_i)             lowcnt <= '0;
      else if (lowcnt != '1) lowcnt <= lowcnt + LW'(1);
    end
  end

  // a reported break always follows a long enough dominant run
  assert_break_len_R1: assert property (@(posedge clk) disable iff (rst)
    brk_o |-> ($past(lowcnt) >= $past(thr)));
endmodule

// File: rtl/lin_baud_meas.sv
module lin_baud_meas
  import lin_sync_pkg::*;
#(
  parameter int CW      = 16,
  parameter int EDGES   = 4,
  parameter int SHIFT   = 3,
  parameter int TOL_NUM = 7,
  parameter int TOL_DEN = 50,
  parameter int TO_BITS = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          brk_i,
  input  logic          fall_i,
  input  logic [CW-1:0] nom_i,
  output logic          ok_o,
  output logic          fail_o,
  output logic [CW-1:0] period_o
);
  localparam int MW = CW + SHIFT;
  localparam int TW = CW + 6;
  localparam int XW = CW + 8;
  localparam int EW = $clog2(EDGES + 1);

  meas_st_e      st;
  logic [MW-1:0] cnt;
  logic [TW-1:0] tocnt;
  logic [EW-1:0] nfall;
  logic [CW-1:0] per_w, dev_w, odev_w;
  logic          in_tol, to_hit, out_in_tol;

  assign per_w  = cnt[SHIFT +: CW];
  assign dev_w  = (per_w > nom_i) ? per_w - nom_i : nom_i - per_w;
  assign in_tol = (XW'(dev_w) * XW'(TOL_DEN)) <= (XW'(nom_i) * XW'(TOL_NUM));
  assign to_hit = tocnt >= (TW'(nom_i) * TW'(TO_BITS));

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= M_IDLE;
      cnt      <= '0;
      tocnt    <= '0;
      nfall    <= '0;
      ok_o     <= 1'b0;
      fail_o   <= 1'b0;
      period_o <= '0;
    end else begin
      ok_o   <= 1'b0;
      fail_o <= 1'b0;
      if (brk_i) begin
        st    <= M_FIRST;
        tocnt <= '0;
      end else begin
        case (st)
          M_FIRST: begin
            if (fall_i) begin
              st    <= M_MEAS;
              cnt   <= MW'(1);
              nfall <= '0;
              tocnt <= '0;
            end else if (to_hit) begin
              fail_o <= 1'b1;
              st     <= M_IDLE;
            end else tocnt <= tocnt + TW'(1);
          end
          M_MEAS: begin
            cnt <= cnt + MW'(1);
            if (fall_i) begin
              tocnt <= '0;
              if (nfall == EW'(EDGES - 1)) begin
                st <= M_IDLE;
                if (in_tol) begin
                  ok_o     <= 1'b1;
                  period_o <= per_w;
                end else fail_o <= 1'b1;
              end else nfall <= nfall + EW'(1);
            end else if (to_hit) begin
              fail_o <= 1'b1;
              st     <= M_IDLE;
            end else tocnt <= tocnt + TW'(1);
          end
          default: ;
        endcase
      end
    end
  end

  assign odev_w     = (period_o > nom_i) ? period_o - nom_i : nom_i - period_o;
  assign out_in_tol = (XW'(odev_w) * XW'(TOL_DEN)) <= (XW'(nom_i) * XW'(TOL_NUM));

  assert_ok_within_tol_R3: assert property (@(posedge clk) disable iff (rst)
    ok_o |-> out_in_tol);
  assert_fail_returns_R4: assert property (@(posedge clk) disable iff (rst)
    fail_o |-> (st == M_IDLE));
endmodule

// File: rtl/lin_id_rx.sv
module lin_id_rx
  import lin_sync_pkg::*;
#(
  parameter int CW      = 16,
  parameter int TO_BITS = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             brk_i,
  input  logic             fall_i,
  input  logic             lvl_i,
  input  logic [CW-1:0]    div_i,
  input  logic [CW-1:0]    nom_i,
  input  logic [MAP_W-1:0] map_i,
  output logic [ID_W-1:0]  id_o,
  output logic             valid_o,
  output logic [1:0]       action_o,
  output logic [3:0]       len_o,
  output logic             perr_o
);
  localparam int TW = CW + 6;

  idrx_st_e      st;
  logic [CW:0]   tmr;
  logic [2:0]    bitn;
  logic [7:0]    sh;
  logic [7:0]    byte_w;
  logic [TW-1:0] tocnt;
  logic [1:0]    code_w;
  logic          bad_w;

  assign byte_w = {lvl_i, sh[7:1]};
  assign bad_w  = byte_w[7:6] != id_parity(byte_w[5:0]);
  assign code_w = map_i[{byte_w[5:0], 1'b0} +: 2];

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= I_IDLE; tmr <= '0; bitn <= '0; sh <= '0; tocnt <= '0;
      id_o <= '0; valid_o <= 1'b0; action_o <= ACT_IGNORE; len_o <= '0; perr_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      perr_o  <= 1'b0;
      if (brk_i) st <= I_IDLE;
      else begin
        case (st)
          I_IDLE: if (start_i) begin
            st    <= I_WAIT;
            tocnt <= '0;
          end
          I_WAIT: begin
            if (fall_i) begin
              tmr  <= (CW+1)'(div_i) + (CW+1)'(div_i >> 1) - (CW+1)'(1);
              bitn <= '0;
              st   <= I_DATA;
            end else if (tocnt >= TW'(nom_i) * TW'(TO_BITS)) st <= I_IDLE;
            else tocnt <= tocnt + TW'(1);
          end
          I_DATA: begin
            if (tmr == '0) begin
              sh   <= byte_w;
              tmr  <= (CW+1)'(div_i) - (CW+1)'(1);
              bitn <= bitn + 3'd1;
              if (bitn == 3'd7) begin
                st       <= I_IDLE;
                id_o     <= byte_w[5:0];
                len_o    <= id_resp_len(byte_w[5:0]);
                valid_o  <= 1'b1;
                perr_o   <= bad_w;
                action_o <= (bad_w || code_w == 2'b11) ? ACT_IGNORE : code_w;
              end
            end else tmr <= tmr - (CW+1)'(1);
          end
          default: st <= I_IDLE;
        endcase
      end
    end
  end

  assert_perr_ignores_R7: assert property (@(posedge clk) disable iff (rst)
    (valid_o && perr_o) |-> (action_o == ACT_IGNORE));
  assert_action_legal_R6: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (action_o != 2'b11));
  assert_gated_by_sync_R5: assert property (@(posedge clk) disable iff (rst)
    (st == I_WAIT && $past(st) == I_IDLE) |-> $past(start_i));
endmodule

// File: rtl/lin_sync_rx.sv
module lin_sync_rx
  import lin_sync_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_i,
  input  logic [CW-1:0]    nom_period_i,
  input  logic [MAP_W-1:0] act_map_i,
  output logic [CW-1:0]    divisor_o,
  output logic             sync_ok_o,
  output logic             sync_fail_o,
  output logic [ID_W-1:0]  id_o,
  output logic             id_valid_o,
  output logic [1:0]       action_o,
  output logic [3:0]       resp_len_o,
  output logic             parity_err_o
);
  logic lvl, fall, rise, brk;

  lin_rx_front #(.STAGES(2)) u_front (
    .clk(clk), .rst(rst), .rx_i(rx_i), .lvl_o(lvl), .fall_o(fall), .rise_o(rise));

  lin_break_det #(.CW(CW), .MIN_BITS(11)) u_brk (
    .clk(clk), .rst(rst), .lvl_i(lvl), .rise_i(rise), .nom_i(nom_period_i), .brk_o(brk));

  lin_baud_meas #(.CW(CW)) u_meas (
    .clk(clk), .rst(rst), .brk_i(brk), .fall_i(fall), .nom_i(nom_period_i),
    .ok_o(sync_ok_o), .fail_o(sync_fail_o), .period_o(divisor_o));

  lin_id_rx #(.CW(CW)) u_id (
    .clk(clk), .rst(rst), .start_i(sync_ok_o), .brk_i(brk), .fall_i(fall), .lvl_i(lvl),
    .div_i(divisor_o), .nom_i(nom_period_i), .map_i(act_map_i), .id_o(id_o),
    .valid_o(id_valid_o), .action_o(action_o), .len_o(resp_len_o), .perr_o(parity_err_o));

  assert_sync_excl_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sync_ok_o, sync_fail_o}));
endmodule

// File: tb/tb_lin_sync_rx.sv
module tb_lin_sync_rx;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;
  localparam int PN = 40;

  logic clk = 1'b0, rst = 1'b1, rx = 1'b1;
  logic [CW-1:0] nom = CW'(PN);
  logic [127:0] map;
  logic [CW-1:0] divisor;
  logic sync_ok, sync_fail, id_valid, parity_err;
  logic [5:0] id;
  logic [1:0] action;
  logic [3:0] resp_len;

  always #(CLK_PERIOD/2) clk = ~clk;

  lin_sync_rx #(.CW(CW)) dut (
    .clk(clk), .rst(rst), .rx_i(rx), .nom_period_i(nom), .act_map_i(map),
    .divisor_o(divisor), .sync_ok_o(sync_ok), .sync_fail_o(sync_fail), .id_o(id),
    .id_valid_o(id_valid), .action_o(action), .resp_len_o(resp_len), .parity_err_o(parity_err));

  int n_chk = 0, n_bad = 0;
  int c_ok = 0, c_fail = 0, c_idv = 0, c_perr = 0;
  int cap_div = 0, cap_id = 0, cap_act = 0, cap_len = 0, cap_perr = 0;

  always @(negedge clk) if (!rst) begin
    if (sync_ok)   begin c_ok++; cap_div = int'(divisor); end
    if (sync_fail) c_fail++;
    if (parity_err) c_perr++;
    if (id_valid) begin
      c_idv++; cap_id = int'(id); cap_act = int'(action);
      cap_len = int'(resp_len); cap_perr = int'(parity_err);
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic logic [1:0] par_of(input logic [5:0] i);
    return {~(i[1] ^ i[3] ^ i[4] ^ i[5]), i[0] ^ i[1] ^ i[2] ^ i[4]};
  endfunction
  function automatic int exp_act(input logic [5:0] i, input logic bad);
    logic [1:0] m;
    m = map[2*i +: 2];
    return (bad || m == 2'b11) ? 0 : int'(m);
  endfunction
  function automatic int exp_len(input logic [5:0] i);
    return (i[5:4] == 2'b11) ? 8 : (i[5:4] == 2'b10) ? 4 : 2;
  endfunction

  task automatic hold(input logic v, input int n);
    rx = v;
    repeat (n) @(negedge clk);
  endtask
  task automatic send_byte(input logic [7:0] b, input int pm);
    hold(1'b0, pm);
    for (int i = 0; i < 8; i++) hold(b[i], pm);
    hold(1'b1, pm);
  endtask
  task automatic frame(input int brk, input int pm, input logic [7:0] idb);
    hold(1'b0, brk);
    hold(1'b1, pm);
    send_byte(8'h55, pm);
    send_byte(idb, pm);
    hold(1'b1, 6 * pm);
  endtask

  // full good-or-parity-bad frame with checks on every result
  task automatic good_frame(input int brk, input int pm, input logic [5:0] i, input logic bad);
    int b_ok, b_fail, b_idv;
    logic [1:0] p;
    b_ok = c_ok; b_fail = c_fail; b_idv = c_idv;
    p = par_of(i) ^ (bad ? 2'b10 : 2'b00);
    frame(brk, pm, {p, i});
    chk("R1/R2 sync_ok count", c_ok - b_ok, 1);
    chk("R3 no sync_fail", c_fail - b_fail, 0);
    chk("R2 divisor", cap_div, pm);
    chk("R5 id_valid count", c_idv - b_idv, 1);
    chk("R5 id value", cap_id, int'(i));
    chk("R6 action", cap_act, exp_act(i, bad));
    chk("R7 parity flag", cap_perr, int'(bad));
    chk("R8 resp length", cap_len, exp_len(i));
  endtask

  task automatic bad_sync_frame(input int brk, input int pm, input string what);
    int b_ok, b_fail, b_idv;
    b_ok = c_ok; b_fail = c_fail; b_idv = c_idv;
    frame(brk, pm, {par_of(6'h15), 6'h15});
    chk({what, " sync_fail"}, c_fail - b_fail, 1);
    chk({what, " no sync_ok"}, c_ok - b_ok, 0);
    chk({what, " no id"}, c_idv - b_idv, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    int b_ok, b_fail, b_idv;
    void'($urandom(32'd2024));
    map = {$urandom, $urandom, $urandom, $urandom};
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 sync_ok", int'(sync_ok), 0);
    chk("R10 sync_fail", int'(sync_fail), 0);
    chk("R10 id_valid", int'(id_valid), 0);
    chk("R10 parity_err", int'(parity_err), 0);
    chk("R10 divisor", int'(divisor), 0);
    chk("R10 id/action/len", int'({id, action, resp_len}), 0);
    hold(1'b1, 3 * PN);

    good_frame(13 * PN, PN, 6'h12, 1'b0);
    good_frame(11 * PN, PN, 6'h3C, 1'b0);          // R1 minimum break
    // R1 one cycle short: nothing at all
    b_ok = c_ok; b_fail = c_fail; b_idv = c_idv;
    frame(11 * PN - 1, PN, {par_of(6'h01), 6'h01});
    chk("R1 short break sync_ok", c_ok - b_ok, 0);
    chk("R1 short break sync_fail", c_fail - b_fail, 0);
    chk("R1 short break id", c_idv - b_idv, 0);

    good_frame(13 * 45, 45, 6'h2A, 1'b0);          // R3 inside tolerance
    good_frame(13 * 35, 35, 6'h07, 1'b0);
    bad_sync_frame(13 * 46, 46, "R3 slow");
    bad_sync_frame(13 * 34, 34, "R3 fast");
    good_frame(13 * PN, PN, 6'h30, 1'b1);          // R7 parity error

    // R4 timeout: break then silence
    b_ok = c_ok; b_fail = c_fail;
    hold(1'b0, 13 * PN);
    hold(1'b1, 25 * PN);
    chk("R4 timeout fail", c_fail - b_fail, 1);
    chk("R4 timeout no ok", c_ok - b_ok, 0);

    // R9 break in middle of sync byte restarts
    b_ok = c_ok; b_fail = c_fail; b_idv = c_idv;
    hold(1'b0, 13 * PN); hold(1'b1, PN);
    hold(1'b0, PN); hold(1'b1, PN);
    hold(1'b0, 14 * PN); hold(1'b1, 42);
    send_byte(8'h55, 42);
    send_byte({par_of(6'h21), 6'h21}, 42);
    hold(1'b1, 6 * 42);
    chk("R9 restart ok", c_ok - b_ok, 1);
    chk("R9 restart no fail", c_fail - b_fail, 0);
    chk("R9 restart divisor", cap_div, 42);
    chk("R9 restart id", cap_id, 'h21);
    chk("R9 one id", c_idv - b_idv, 1);

    // random frames
    for (int k = 0; k < 10; k++) begin
      int pm;
      logic [5:0] ri;
      pm = PN - 5 + int'($urandom_range(0, 10));
      ri = 6'($urandom_range(0, 63));
      good_frame(13 * pm, pm, ri, ($urandom_range(0, 3) == 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule